// File: doc/BRIEF.md
# External Bus Cycle Wait-State Controller

This block runs one read or one write at a time on an external memory port for an internal master. The master raises a request with a direction, an address and write data. The block then drives an active-low read or write strobe, drives the data bus on writes, and decodes chip-select lines from the upper address bits. It returns a one-cycle completion pulse together with the read data it captured.

The length of each cycle is set by two things. The first is a programmed minimum wait-state count, taken from a bus control register when the cycle starts. The second is an external acknowledge input. Holding that input at its not-ready level stretches the cycle for as long as it is held. A cycle programmed with zero wait states cannot be stretched at all. A mode bit decides how the acknowledge is sampled: either directly on the clock, or through a two-flop synchronizer. A second mode bit decides how the chip selects are formed: either a priority scheme that asserts at most one line, or all four lines following the address so that external logic can decode them further.

Top module: `ebus_wait_ctrl`

## Requirements
- R1: Synchronous reset (`rst` high) puts the block in idle. In idle, `rd_n` and `wr_n` are 1, `data_oe` is 0, `cs_n` is 4'b1111 and `done` is 0.
- R2: With a programmed count W of 1 or more and the acknowledge ready from the start, the strobe is low for exactly W+1 clock cycles. If `xack_n` first goes low in strobe cycle D (counting from 0) and stays low, the strobe stays low for max(W, D+L)+1 cycles. L is 0 in direct mode and 2 in synchronized mode.
- R3: `min_wait` is captured when a request is accepted. Changing it while a cycle is in progress does not change the length of that cycle.
- R4: When the captured W is 0, the strobe is low for exactly one cycle whatever the level of `xack_n`.
- R5: With `ack_sync_en` = 0, `xack_n` is sampled directly on the clock. With `ack_sync_en` = 1, it passes through two flops first, which delays its effect by two cycles (the L of R2).
- R6: A read cycle (`req_write` = 0) drives only `rd_n` low, and a write cycle drives only `wr_n` low. `strobe_oe` equals `bus_master`, so both strobes are released while the block is not master.
- R7: `data_oe` is 1 only during a write cycle while `bus_master` is 1. `data_out` shows the write data during the cycle and keeps the last written value after the drivers switch off.
- R8: During a cycle, let N be `req_addr[ADDR_W-1 -: 4]`. With `prio_disable` = 0, `cs_n` is the inverse of the lowest set bit of N, or all ones if N is 0. With `prio_disable` = 1, `cs_n` is ~N.
- R9: A request is accepted only when the block is idle and `bus_master` is 1; a request raised during a cycle is dropped. `done` is high for exactly one cycle, the cycle right after the last strobe cycle. In that same cycle, `rdata` holds the `data_in` value sampled at the end of a read cycle.
- R10: Activity on `xack_n` while the block is idle has no effect. No strobe is driven and no `done` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_master | input | 1 | Block currently owns the external bus |
| req | input | 1 | Cycle request from the internal master |
| req_write | input | 1 | Direction: 1 write, 0 read |
| req_addr | input | ADDR_W | Cycle address |
| req_wdata | input | DATA_W | Write data |
| min_wait | input | WS_W | Programmed minimum wait states |
| ack_sync_en | input | 1 | 1 synchronizes the acknowledge through two flops |
| prio_disable | input | 1 | 1 makes the chip selects follow the address directly |
| xack_n | input | 1 | External transfer acknowledge, low means ready |
| data_in | input | DATA_W | Data bus input value |
| data_out | output | DATA_W | Data bus output value, held after the drivers switch off |
| data_oe | output | 1 | Data bus driver enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| strobe_oe | output | 1 | Strobe driver enable |
| cs_n | output | CS_N | Chip selects, active low |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read data |

## Verification
The hardest cases to reach are the ones where the programmed minimum and the acknowledge stretch overlap in time. The two-cycle synchronizer delay makes those overlaps easy to miss. Each table vector therefore releases the acknowledge in a chosen strobe cycle, counting strobe cycles as seen at the ports, so the release can fall before, on or after the programmed minimum in both sampling modes. Directed tests change the register mid-cycle, raise a second request during a cycle and hold the acknowledge not-ready on a zero-wait cycle, and each checks the strobe length that results.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
   typedef enum logic {
      ST_IDLE   = 1'b0,
      ST_ACCESS = 1'b1
   } ebus_state_t;
endpackage

// File: rtl/ebus_ack_sampler.sv
module ebus_ack_sampler #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic ack_n,
   input  logic sync_sel,
   output logic ready
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("ebus_ack_sampler: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[0] <= 1'b0;
               else     chain[0] <= ~ack_n;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[i] <= 1'b0;
               else     chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign ready = sync_sel ? chain[STAGES-1] : ~ack_n;
endmodule

// File: rtl/ebus_wait_timer.sv
module ebus_wait_timer #(
   parameter int WS_W = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start,
   input  logic [WS_W-1:0] load_val,
   input  logic            running,
   input  logic            ack_ready,
   output logic            finish
);
   generate
      if (WS_W < 1) begin : g_bad
         $error("ebus_wait_timer: WS_W must be at least 1");
      end
   endgenerate

   logic [WS_W-1:0] limit_q;
   logic [WS_W-1:0] cnt_q;
   logic            min_met;
   logic            zero_ws;

   assign min_met = (cnt_q >= limit_q);
   assign zero_ws = (limit_q == '0);
   assign finish  = running && min_met && (zero_ws || ack_ready);

   always_ff @(posedge clk) begin
      if (rst) begin
         limit_q <= '0;
         cnt_q   <= '0;
      end else if (start) begin
         limit_q <= load_val;
         cnt_q   <= '0;
      end else if (running && !finish && !min_met) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/ebus_cs_decode.sv
module ebus_cs_decode #(
   parameter int CS_N = 4
) (
   input  logic [CS_N-1:0] match,
   input  logic            prio_disable,
   input  logic            active,
   output logic [CS_N-1:0] cs_n
);
   generate
      if (CS_N < 1) begin : g_bad
         $error("ebus_cs_decode: CS_N must be at least 1");
      end
   endgenerate

   logic [CS_N:0]   blocked;
   logic [CS_N-1:0] prio_sel;

   assign blocked[0] = 1'b0;

   generate
      for (genvar i = 0; i < CS_N; i++) begin : g_prio
         assign prio_sel[i]  = match[i] & ~blocked[i];
         assign blocked[i+1] = blocked[i] | match[i];
      end
   endgenerate

   always_comb begin
      if (!active)          cs_n = '1;
      else if (prio_disable) cs_n = ~match;
      else                  cs_n = ~prio_sel;
   end
endmodule

// File: rtl/ebus_wait_ctrl.sv
module ebus_wait_ctrl
   import ebus_pkg::*;
#(
   parameter int ADDR_W      = 18,
   parameter int DATA_W      = 24,
   parameter int WS_W        = 4,
   parameter int CS_N        = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_master,
   input  logic              req,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [WS_W-1:0]   min_wait,
   input  logic              ack_sync_en,
   input  logic              prio_disable,
   input  logic              xack_n,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   output logic              rd_n,
   output logic              wr_n,
   output logic              strobe_oe,
   output logic [CS_N-1:0]   cs_n,
   output logic              done,
   output logic [DATA_W-1:0] rdata
);
   localparam int CS_LSB = ADDR_W - CS_N;

   generate
      if (ADDR_W < CS_N) begin : g_bad_addr
         $error("ebus_wait_ctrl: ADDR_W must cover the chip-select bits");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("ebus_wait_ctrl: DATA_W must be positive");
      end
   endgenerate

   ebus_state_t       state_q;
   logic              dir_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic              done_q;
   logic              accept;
   logic              in_cycle;
   logic              ack_ready;
   logic              finish;

   assign in_cycle = (state_q == ST_ACCESS);
   assign accept   = (state_q == ST_IDLE) && req && bus_master;

   ebus_ack_sampler #(.STAGES(SYNC_STAGES)) u_ack (
      .clk      (clk),
      .rst      (rst),
      .ack_n    (xack_n),
      .sync_sel (ack_sync_en),
      .ready    (ack_ready)
   );

   ebus_wait_timer #(.WS_W(WS_W)) u_timer (
      .clk       (clk),
      .rst       (rst),
      .start     (accept),
      .load_val  (min_wait),
      .running   (in_cycle),
      .ack_ready (ack_ready),
      .finish    (finish)
   );

   ebus_cs_decode #(.CS_N(CS_N)) u_cs (
      .match        (addr_q[ADDR_W-1:CS_LSB]),
      .prio_disable (prio_disable),
      .active       (in_cycle),
      .cs_n         (cs_n)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         dir_q   <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            state_q <= ST_ACCESS;
            dir_q   <= req_write;
            addr_q  <= req_addr;
            if (req_write) wdata_q <= req_wdata;
         end else if (finish) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            if (!dir_q) rdata_q <= data_in;
         end
      end
   end

   assign rd_n      = ~(in_cycle && !dir_q);
   assign wr_n      = ~(in_cycle && dir_q);
   assign strobe_oe = bus_master;
   assign data_oe   = in_cycle && dir_q && bus_master;
   assign data_out  = wdata_q;
   assign done      = done_q;
   assign rdata     = rdata_q;
endmodule

// File: rtl/ebus_wait_ctrl_chk.sv
module ebus_wait_ctrl_chk #(
   parameter int CS_N = 4
) (
   input logic            clk,
   input logic            rst,
   input logic            bus_master,
   input logic            prio_disable,
   input logic            rd_n,
   input logic            wr_n,
   input logic            strobe_oe,
   input logic            data_oe,
   input logic [CS_N-1:0] cs_n,
   input logic            done
);
   assert_one_strobe_R6: assert property (@(posedge clk) disable iff (rst)
      rd_n || wr_n);

   assert_release_R6: assert property (@(posedge clk) disable iff (rst)
      !bus_master |-> (!strobe_oe && !data_oe));

   assert_drive_write_R7: assert property (@(posedge clk) disable iff (rst)
      data_oe |-> !wr_n);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_done_after_strobe_R9: assert property (@(posedge clk) disable iff (rst)
      done |-> (rd_n && wr_n && $past(!rd_n || !wr_n)));

   assert_cs_single_R8: assert property (@(posedge clk) disable iff (rst)
      !prio_disable |-> $onehot0(~cs_n));

   assert_idle_cs_R1: assert property (@(posedge clk) disable iff (rst)
      (rd_n && wr_n) |-> (&cs_n));
endmodule

bind ebus_wait_ctrl ebus_wait_ctrl_chk #(.CS_N(CS_N)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .bus_master   (bus_master),
   .prio_disable (prio_disable),
   .rd_n         (rd_n),
   .wr_n         (wr_n),
   .strobe_oe    (strobe_oe),
   .data_oe      (data_oe),
   .cs_n         (cs_n),
   .done         (done)
);

// File: tb/ebus_wait_ctrl_test.sv
`timescale 1ns/1ps
module ebus_wait_ctrl_test;
   localparam int ADDR_W = 18;
   localparam int DATA_W = 24;
   localparam int WS_W   = 4;

   typedef struct packed {
      logic              wr;
      logic [3:0]        w;
      logic              sync;
      logic [7:0]        d;
      logic              prio;
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] wdata;
      logic [DATA_W-1:0] rdv;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 4'd0,  1'b0, 8'd0,   1'b0, 18'h3C001, 24'hA5A5A5, 24'h000000},
      '{1'b0, 4'd2,  1'b0, 8'd0,   1'b0, 18'h30010, 24'h000000, 24'h123456},
      '{1'b0, 4'd1,  1'b0, 8'd5,   1'b1, 18'h28020, 24'h000000, 24'hC0FFEE},
      '{1'b1, 4'd3,  1'b1, 8'd1,   1'b0, 18'h20030, 24'h5A5A5A, 24'h000000},
      '{1'b0, 4'd2,  1'b1, 8'd4,   1'b1, 18'h00040, 24'h000000, 24'h0BEEF0},
      '{1'b1, 4'd15, 1'b0, 8'd0,   1'b0, 18'h14050, 24'h3C3C3C, 24'h000000},
      '{1'b0, 4'd1,  1'b1, 8'd0,   1'b1, 18'h18060, 24'h000000, 24'h777777},
      '{1'b0, 4'd0,  1'b1, 8'd200, 1'b0, 18'h24070, 24'h000000, 24'h999999}
   };

   logic              clk = 1'b0;
   logic              rst;
   logic              bus_master;
   logic              req;
   logic              req_write;
   logic [ADDR_W-1:0] req_addr;
   logic [DATA_W-1:0] req_wdata;
   logic [WS_W-1:0]   min_wait;
   logic              ack_sync_en;
   logic              prio_disable;
   logic              xack_n;
   logic [DATA_W-1:0] data_in;
   logic [DATA_W-1:0] data_out;
   logic              data_oe;
   logic              rd_n;
   logic              wr_n;
   logic              strobe_oe;
   logic [3:0]        cs_n;
   logic              done;
   logic [DATA_W-1:0] rdata;

   int checks   = 0;
   int failures = 0;
   int cycles   = 0;
   int mid_w    = -1;
   int extra_k  = -1;

   always #4 clk = ~clk;

   ebus_wait_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W)) uut (
      .clk(clk), .rst(rst), .bus_master(bus_master), .req(req),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .min_wait(min_wait), .ack_sync_en(ack_sync_en),
      .prio_disable(prio_disable), .xack_n(xack_n), .data_in(data_in),
      .data_out(data_out), .data_oe(data_oe), .rd_n(rd_n), .wr_n(wr_n),
      .strobe_oe(strobe_oe), .cs_n(cs_n), .done(done), .rdata(rdata)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         failures = failures + 1;
         checks   = checks + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
         $finish;
      end
   end

   task automatic check(input logic ok, input string what, input longint act, input longint exp);
      checks = checks + 1;
      if (!ok) begin
         failures = failures + 1;
         $display("FAIL %s: actual 'h%0h expected 'h%0h", what, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_cs(input logic [3:0] nib, input logic pd);
      if (pd) return ~nib;
      return ~(nib & (~nib + 4'd1));
   endfunction

   function automatic int exp_len(input int w, input int d, input logic sync);
      int stretch;
      if (w == 0) return 1;
      stretch = d + (sync ? 2 : 0);
      return ((w > stretch) ? w : stretch) + 1;
   endfunction

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic run_cycle(input vec_t v, input int w_exp);
      int  k;
      logic active;
      @(negedge clk);
      req_write    = v.wr;
      req_addr     = v.addr;
      req_wdata    = v.wdata;
      min_wait     = v.w;
      ack_sync_en  = v.sync;
      prio_disable = v.prio;
      data_in      = v.rdv;
      xack_n       = 1'b1;
      req          = 1'b1;
      @(negedge clk);
      k = 0;
      for (int guard = 0; guard < 300; guard++) begin
         active = !rd_n || !wr_n;
         if (!active) break;
         if (k == 0) begin
            check(cs_n == exp_cs(v.addr[ADDR_W-1 -: 4], v.prio), "R8 chip selects",
                  cs_n, exp_cs(v.addr[ADDR_W-1 -: 4], v.prio));
            check({rd_n, wr_n} == (v.wr ? 2'b10 : 2'b01), "R6 strobe direction",
                  {rd_n, wr_n}, v.wr ? 2'b10 : 2'b01);
            check(data_oe == v.wr, "R7 driver enable in cycle", data_oe, v.wr);
            if (v.wr) check(data_out == v.wdata, "R7 write data", data_out, v.wdata);
            if (mid_w >= 0) min_wait = mid_w[WS_W-1:0];
         end
         check(done == 1'b0, "R9 no done during strobe", done, 0);
         if (k == int'(v.d)) xack_n = 1'b0;
         req = (k == extra_k);
         k++;
         @(negedge clk);
      end
      req = 1'b0;
      check(k == w_exp, "R2 strobe length", k, w_exp);
      check(done == 1'b1, "R9 done after last strobe", done, 1);
      if (!v.wr) check(rdata == v.rdv, "R9 read data", rdata, v.rdv);
      @(negedge clk);
      xack_n = 1'b1;
      check(done == 1'b0, "R9 done single pulse", done, 0);
      check(rd_n && wr_n, "R9 no extra cycle", {rd_n, wr_n}, 2'b11);
      if (v.wr) begin
         check(data_oe == 1'b0, "R7 drivers off", data_oe, 0);
         check(data_out == v.wdata, "R7 keeper holds", data_out, v.wdata);
      end
      idle(4);
   endtask

   initial begin
      vec_t t;
      rst = 1'b1; bus_master = 1'b1; req = 1'b0; req_write = 1'b0;
      req_addr = '0; req_wdata = '0; min_wait = '0; ack_sync_en = 1'b0;
      prio_disable = 1'b0; xack_n = 1'b1; data_in = '0;
      idle(3);
      // R1: reset state
      check(rd_n && wr_n, "R1 strobes idle", {rd_n, wr_n}, 2'b11);
      check(data_oe == 1'b0, "R1 data drivers off", data_oe, 0);
      check(cs_n == 4'hF, "R1 chip selects idle", cs_n, 4'hF);
      check(done == 1'b0, "R1 done low", done, 0);
      rst = 1'b0;
      idle(2);

      // Table walk: R2, R4, R5, R6, R7, R8, R9
      for (int i = 0; i < NV; i++) begin
         run_cycle(VECS[i], exp_len(VECS[i].w, VECS[i].d, VECS[i].sync));
      end

      // R10: acknowledge while idle has no effect
      xack_n = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(rd_n && wr_n && !done, "R10 idle ack ignored", {rd_n, wr_n, done}, 3'b110);
      end
      xack_n = 1'b1;
      idle(4);

      // R3: register change mid-cycle does not alter the cycle
      t = VECS[1]; t.w = 4'd2; t.d = 8'd0; t.sync = 1'b0;
      mid_w = 7;
      run_cycle(t, 3);
      mid_w = -1;

      // R9: request raised during a cycle is dropped
      t = VECS[3]; t.w = 4'd3; t.d = 8'd0; t.sync = 1'b0;
      extra_k = 1;
      run_cycle(t, 4);
      extra_k = -1;

      // R4: zero wait states, acknowledge held not-ready, direct mode
      t = VECS[7]; t.sync = 1'b0; t.d = 8'd255;
      run_cycle(t, 1);

      // R6 / R9: not bus master, request is refused and strobes released
      @(negedge clk);
      bus_master = 1'b0; req = 1'b1; req_write = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(!strobe_oe && !data_oe, "R6 released when not master", {strobe_oe, data_oe}, 2'b00);
         check(!done, "R9 no done without mastership", done, 0);
      end
      req = 1'b0; bus_master = 1'b1;
      @(negedge clk);
      check(rd_n && wr_n && strobe_oe, "R9 refused request started nothing",
            {rd_n, wr_n, strobe_oe}, 3'b111);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
   end
endmodule